// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Multiply Divider

This block divides an unsigned N-bit dividend by a divisor that stays fixed for a given configuration. It does not iterate. It multiplies the dividend by a precomputed fixed-point reciprocal, keeps the upper N bits of the 2N-bit product, and shifts that value right. The reciprocal is rounded upward, so the truncation at the end gives the exact floor quotient, including for exact multiples of the divisor.

Some divisors need an N+1-bit reciprocal. For these, the multiplier input holds only the low N bits. A subtract-halve-add correction rebuilds the high product half without any carry out of N bits. Divisors above 2^(N-1) need no multiply: the quotient is a single comparison. Power-of-two divisors also need no multiply: the quotient is a plain right shift.

Software or an upstream generator produces the configuration bundle: multiplier, shift count and mode. The block samples that bundle together with each valid dividend. It accepts one operation per clock and returns each quotient a fixed two cycles later.

Top module: `recip_divider`

## Requirements
- R1: While reset is high and on the first cycle after it falls, out_valid is low and out_quotient is zero.
- R2: An operation accepted on a clock edge (in_valid high) produces out_valid high exactly two edges later. out_valid is never high in any other cycle. Back-to-back operations come out in order, one per cycle.
- R3: With cfg_mode = 0 (multiply), out_quotient equals the upper N bits of in_dividend × cfg_mult, shifted right by cfg_shift.
- R4: With cfg_mode = 1 (wide reciprocal), cfg_mult holds the low N bits of an N+1-bit reciprocal, and cfg_shift is at least 1. The block forms hi from the product as in R3, then t = (in_dividend − hi) >> 1, and the quotient is (hi + t) >> (cfg_shift − 1). The result is exact even for an all-ones dividend, where adding the dividend to hi directly would overflow.
- R5: With cfg_mode = 2 (compare), cfg_mult carries the divisor itself. out_quotient is 1 when in_dividend ≥ cfg_mult and 0 otherwise.
- R6: With cfg_mode = 3 (shift), out_quotient is in_dividend >> cfg_shift, and cfg_mult has no effect on the result.
- R7: The configuration is captured with the dividend it accompanies. Operations in consecutive cycles with different configurations each use their own.
- R8: For N = 64, the divisor 5 uses multiplier 0xCCCCCCCCCCCCCCCD with cfg_mode 0 and shift 2. The result equals floor(dividend / 5) for every dividend, including zero, exact multiples and the all-ones value.
- R9: Cycles with in_valid low start no operation. Any values on the data and configuration inputs during such cycles are ignored. out_quotient holds its last value whenever out_valid is low.
- R10: With configurations built by the reciprocal rule (round the reciprocal up), the result equals floor(dividend / divisor) for every divisor. At N = 16 this holds for all 65536 dividends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the dividend and configuration this cycle |
| in_dividend | input | N | Unsigned dividend |
| cfg_mult | input | N | Reciprocal (low N bits in wide mode), or the divisor in compare mode |
| cfg_shift | input | $clog2(N) | Post-shift count |
| cfg_mode | input | 2 | 0 multiply, 1 wide reciprocal, 2 compare, 3 shift only |
| out_valid | output | 1 | Quotient valid |
| out_quotient | output | N | Unsigned quotient |

## Verification
Every quotient, and the out_valid pulse that qualifies it, is due on the second rising edge after the edge that accepted the operation. The first edge loads the product register, and the second loads the output register. The bench tags each issued operation with the cycle number it is due in. It samples the outputs shortly after each rising edge and compares the quotient only in the cycle whose number matches the head of its queue. A valid pulse in any other cycle, or a missing one, fails the latency check, and idle cycles confirm that the quotient holds its value.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  typedef enum logic [1:0] {
    RD_MUL   = 2'd0,
    RD_WIDE  = 2'd1,
    RD_CMP   = 2'd2,
    RD_SHIFT = 2'd3
  } rd_mode_e;

endpackage

// File: rtl/recip_rshift.sv
// Logarithmic right shifter: one constant-distance stage per amount bit.
module recip_rshift #(
  parameter int N   = 64,
  parameter int SHW = $clog2(N)
) (
  input  logic [N-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [N-1:0]   dout
);

  logic [N-1:0] stage [0:SHW];

  assign stage[0] = din;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int DIST = 2 ** g;
    assign stage[g+1] = amt[g] ? (stage[g] >> DIST) : stage[g];
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/recip_mulhi_stage.sv
// Stage 1: full-width multiply, keep the high half, register it together
// with the sampled configuration.
module recip_mulhi_stage
  import recip_div_pkg::*;
#(
  parameter int N   = 64,
  parameter int SHW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_dividend,
  input  logic [N-1:0]   in_mult,
  input  logic [SHW-1:0] in_shift,
  input  rd_mode_e       in_mode,
  output logic           s1_valid,
  output logic [N-1:0]   s1_dividend,
  output logic [N-1:0]   s1_hi,
  output logic [N-1:0]   s1_mult,
  output logic [SHW-1:0] s1_shift,
  output rd_mode_e       s1_mode
);

  localparam int PW = 2 * N;

  logic [PW-1:0] prod;

  assign prod = PW'(in_dividend) * PW'(in_mult);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  // Data registers load only with an accepted operation.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_dividend <= in_dividend;
      s1_hi       <= prod[PW-1:N];
      s1_mult     <= in_mult;
      s1_shift    <= in_shift;
      s1_mode     <= in_mode;
    end
  end

endmodule

// File: rtl/recip_post_stage.sv
// Stage 2: wide-reciprocal correction, compare path, shared post-shifter,
// registered output.
module recip_post_stage
  import recip_div_pkg::*;
#(
  parameter int N   = 64,
  parameter int SHW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s1_valid,
  input  logic [N-1:0]   s1_dividend,
  input  logic [N-1:0]   s1_hi,
  input  logic [N-1:0]   s1_mult,
  input  logic [SHW-1:0] s1_shift,
  input  rd_mode_e       s1_mode,
  output logic           out_valid,
  output logic [N-1:0]   out_quotient
);

  localparam logic [SHW-1:0] SH_ONE = SHW'(1);

  logic [N-1:0]   gap;
  logic [N-1:0]   fixed_hi;
  logic [N-1:0]   shift_src;
  logic [SHW-1:0] shift_amt;
  logic [N-1:0]   shifted;
  logic           at_least;
  logic [N-1:0]   result;

  // hi never exceeds the dividend, so the gap is non-negative and the
  // halved gap added back to hi stays inside N bits.
  assign gap      = s1_dividend - s1_hi;
  assign fixed_hi = s1_hi + (gap >> 1);
  assign at_least = (s1_dividend >= s1_mult);

  always_comb begin
    shift_src = s1_hi;
    shift_amt = s1_shift;
    unique case (s1_mode)
      RD_MUL: begin
        shift_src = s1_hi;
        shift_amt = s1_shift;
      end
      RD_WIDE: begin
        shift_src = fixed_hi;
        shift_amt = (s1_shift == '0) ? '0 : (s1_shift - SH_ONE);
      end
      RD_SHIFT: begin
        shift_src = s1_dividend;
        shift_amt = s1_shift;
      end
      RD_CMP: begin
        shift_src = s1_hi;
        shift_amt = '0;
      end
      default: begin
        shift_src = s1_hi;
        shift_amt = s1_shift;
      end
    endcase
  end

  recip_rshift #(.N(N), .SHW(SHW)) u_shift (
    .din  (shift_src),
    .amt  (shift_amt),
    .dout (shifted)
  );

  assign result = (s1_mode == RD_CMP) ? {{(N-1){1'b0}}, at_least} : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_quotient <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_quotient <= result;
      end
    end
  end

endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int N = 64,
  localparam int SHW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_dividend,
  input  logic [N-1:0]   cfg_mult,
  input  logic [SHW-1:0] cfg_shift,
  input  logic [1:0]     cfg_mode,
  output logic           out_valid,
  output logic [N-1:0]   out_quotient
);

  logic           s1_valid;
  logic [N-1:0]   s1_dividend;
  logic [N-1:0]   s1_hi;
  logic [N-1:0]   s1_mult;
  logic [SHW-1:0] s1_shift;
  rd_mode_e       s1_mode;
  rd_mode_e       in_mode;

  assign in_mode = rd_mode_e'(cfg_mode);

  recip_mulhi_stage #(.N(N), .SHW(SHW)) u_mulhi (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dividend (in_dividend),
    .in_mult     (cfg_mult),
    .in_shift    (cfg_shift),
    .in_mode     (in_mode),
    .s1_valid    (s1_valid),
    .s1_dividend (s1_dividend),
    .s1_hi       (s1_hi),
    .s1_mult     (s1_mult),
    .s1_shift    (s1_shift),
    .s1_mode     (s1_mode)
  );

  recip_post_stage #(.N(N), .SHW(SHW)) u_post (
    .clk          (clk),
    .rst          (rst),
    .s1_valid     (s1_valid),
    .s1_dividend  (s1_dividend),
    .s1_hi        (s1_hi),
    .s1_mult      (s1_mult),
    .s1_shift     (s1_shift),
    .s1_mode      (s1_mode),
    .out_valid    (out_valid),
    .out_quotient (out_quotient)
  );

endmodule

// File: rtl/recip_divider_checker.sv
module recip_divider_checker #(
  parameter int N = 64,
  localparam int SHW = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N-1:0]   in_dividend,
  input logic [SHW-1:0] cfg_shift,
  input logic [1:0]     cfg_mode,
  input logic           out_valid,
  input logic [N-1:0]   out_quotient
);

  localparam logic [SHW-1:0] SH_ONE = SHW'(1);
  localparam logic [N-1:0]   Q_ONE  = N'(1);

  logic           v1, v2, was_rst;
  logic [1:0]     md1, md2;
  logic [N-1:0]   dv1, dv2;
  logic [SHW-1:0] sh1, sh2;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
      md1 <= '0; md2 <= '0;
      dv1 <= '0; dv2 <= '0;
      sh1 <= '0; sh2 <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1;
      md1 <= cfg_mode; md2 <= md1;
      dv1 <= in_dividend; dv2 <= dv1;
      sh1 <= cfg_shift; sh2 <= sh1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (!out_valid && out_quotient == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  assert_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && md2 == 2'd0) |-> (out_quotient <= (dv2 >> sh2)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && md2 == 2'd1 && sh2 != '0) |-> (out_quotient <= (dv2 >> (sh2 - SH_ONE))));

  assert_cmp_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && md2 == 2'd2) |-> (out_quotient <= Q_ONE));

  assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && md2 == 2'd3) |-> (out_quotient == (dv2 >> sh2)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(out_quotient));

endmodule

bind recip_divider recip_divider_checker #(.N(N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_dividend  (in_dividend),
  .cfg_shift    (cfg_shift),
  .cfg_mode     (cfg_mode),
  .out_valid    (out_valid),
  .out_quotient (out_quotient)
);

// File: tb/test_recip_divider.sv
module test_recip_divider;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // 64-bit instance
  logic        a_vld = 1'b0;
  logic [63:0] a_dvd = '0, a_mult = '0;
  logic [5:0]  a_sh = '0;
  logic [1:0]  a_md = '0;
  logic        a_ov;
  logic [63:0] a_q;

  // 16-bit instance for exhaustive runs
  logic        b_vld = 1'b0;
  logic [15:0] b_dvd = '0, b_mult = '0;
  logic [3:0]  b_sh = '0;
  logic [1:0]  b_md = '0;
  logic        b_ov;
  logic [15:0] b_q;

  recip_divider #(.N(64)) i_recip_divider (
    .clk(clk), .rst(rst), .in_valid(a_vld), .in_dividend(a_dvd),
    .cfg_mult(a_mult), .cfg_shift(a_sh), .cfg_mode(a_md),
    .out_valid(a_ov), .out_quotient(a_q));

  recip_divider #(.N(16)) i_recip_divider_n16 (
    .clk(clk), .rst(rst), .in_valid(b_vld), .in_dividend(b_dvd),
    .cfg_mult(b_mult), .cfg_shift(b_sh), .cfg_mode(b_md),
    .out_valid(b_ov), .out_quotient(b_q));

  typedef struct {
    logic [63:0] q;
    int          due;
    string       req;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reciprocal constants from the round-up rule, width w.
  task automatic make_cfg(input int w, input logic [63:0] d,
                          output logic [63:0] m, output int sh, output logic [1:0] md);
    logic [129:0] d130, lo, hi;
    int l;
    d130 = 130'(d);
    m = '0; sh = 0; md = 2'd0;
    if ((d & (d - 64'd1)) == 64'd0) begin
      md = 2'd3;
      l = 0;
      while ((130'd1 << l) < d130) l++;
      sh = l;
    end else if (d130 > (130'd1 << (w - 1))) begin
      md = 2'd2; m = d; sh = 0;
    end else begin
      l = 0;
      while ((130'd1 << l) < d130) l++;
      lo = (130'd1 << (w + l)) / d130;
      hi = ((130'd1 << (w + l)) + (130'd1 << l)) / d130;
      sh = l;
      while (((lo >> 1) < (hi >> 1)) && sh > 0) begin
        lo = lo >> 1; hi = hi >> 1; sh--;
      end
      if (hi < (130'd1 << w)) begin
        md = 2'd0; m = hi[63:0];
      end else begin
        md = 2'd1; m = hi[63:0] & ((w == 64) ? ~64'd0 : ((64'd1 << w) - 64'd1));
      end
    end
  endtask

  task automatic put_a(logic [63:0] n, logic [63:0] m, int sh, logic [1:0] md,
                       logic [63:0] expq, string req);
    exp_t e;
    @(negedge clk);
    a_vld = 1'b1; a_dvd = n; a_mult = m; a_sh = sh[5:0]; a_md = md;
    e.q = expq; e.due = cyc + 2; e.req = req;
    qa.push_back(e);
  endtask

  task automatic idle_a();
    @(negedge clk);
    a_vld = 1'b0;
    a_dvd = {$urandom, $urandom}; a_mult = {$urandom, $urandom};
    a_sh = 6'($urandom); a_md = 2'($urandom);
  endtask

  task automatic put_b(logic [15:0] n, logic [15:0] m, int sh, logic [1:0] md,
                       logic [15:0] expq, string req);
    exp_t e;
    @(negedge clk);
    b_vld = 1'b1; b_dvd = n; b_mult = m; b_sh = sh[3:0]; b_md = md;
    e.q = 64'(expq); e.due = cyc + 2; e.req = req;
    qb.push_back(e);
  endtask

  task automatic idle_b();
    @(negedge clk);
    b_vld = 1'b0;
    b_dvd = 16'($urandom); b_mult = 16'($urandom); b_sh = 4'($urandom); b_md = 2'($urandom);
  endtask

  function automatic string mode_tag(logic [1:0] md);
    case (md)
      2'd0: return "R3/R10";
      2'd1: return "R4/R10";
      2'd2: return "R5/R10";
      default: return "R6/R10";
    endcase
  endfunction

  // Monitors sample 1 ns after each rising edge.
  logic [63:0] a_last = '0, b_last = '0;

  initial begin
    forever begin
      @(posedge clk); #1;
      if (mon_on) begin
        if (qa.size() > 0 && qa[0].due < cyc) begin
          check("R2 missing valid (64)", 64'd0, 64'd1);
          void'(qa.pop_front());
        end
        if (qa.size() > 0 && qa[0].due == cyc) begin
          check({qa[0].req, " valid latency (64)"}, 64'(a_ov), 64'd1);
          check({qa[0].req, " quotient (64)"}, a_q, qa[0].q);
          void'(qa.pop_front());
        end else begin
          check("R2 stray valid (64)", 64'(a_ov), 64'd0);
          check("R9 quotient hold (64)", a_q, a_last);
        end
        a_last = a_q;

        if (qb.size() > 0 && qb[0].due < cyc) begin
          check("R2 missing valid (16)", 64'd0, 64'd1);
          void'(qb.pop_front());
        end
        if (qb.size() > 0 && qb[0].due == cyc) begin
          check({qb[0].req, " valid latency (16)"}, 64'(b_ov), 64'd1);
          check({qb[0].req, " quotient (16)"}, 64'(b_q), qb[0].q);
          void'(qb.pop_front());
        end else begin
          check("R2 stray valid (16)", 64'(b_ov), 64'd0);
          check("R9 quotient hold (16)", 64'(b_q), b_last);
        end
        b_last = 64'(b_q);
      end
    end
  end

  task automatic run_a();
    logic [63:0] d, n, m;
    int sh;
    logic [1:0] md;
    logic [63:0] top1;
    top1 = 64'd1 << 63;

    // R8: literal constant for divisor 5
    put_a(64'd9, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'd1, "R8 n=9");
    put_a(64'd0, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'd0, "R8 n=0");
    put_a(~64'd0, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'h3333333333333333, "R8 n=max");
    put_a(64'd5 * 64'h1234567, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'h1234567, "R8 exact multiple");
    put_a(64'd5 * 64'h1234567 - 64'd1, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'h1234566, "R8 multiple-1");
    idle_a();
    // R4: divisor 7, all-ones dividend (direct add would overflow)
    make_cfg(64, 64'd7, m, sh, md);
    check("R4 divisor 7 selects wide mode", 64'(md), 64'd1);
    put_a(~64'd0, m, sh, md, (~64'd0) / 64'd7, "R4 n=max d=7");
    put_a(64'd7 * 64'h0FFFFFFFFFFFFFFF, m, sh, md, 64'h0FFFFFFFFFFFFFFF, "R4 exact d=7");
    // R5: compare path around the divisor
    d = top1 + 64'd12345;
    put_a(d, d, 0, 2'd2, 64'd1, "R5 n=d");
    put_a(d - 64'd1, d, 0, 2'd2, 64'd0, "R5 n=d-1");
    put_a(~64'd0, d, 0, 2'd2, 64'd1, "R5 n=max");
    // R6: shift path with junk in the multiplier
    put_a(64'hF0F0_0000_1234_5678, 64'hDEAD_BEEF_0BAD_F00D, 0, 2'd3, 64'hF0F0_0000_1234_5678, "R6 d=1");
    put_a(~64'd0, 64'h1357_9BDF_2468_ACE0, 63, 2'd3, 64'd1, "R6 d=2^63");
    idle_a(); idle_a(); idle_a();
    // R7: four configurations in consecutive cycles
    put_a(64'd100, 64'hCCCCCCCCCCCCCCCD, 2, 2'd0, 64'd20, "R7 cfg d=5");
    put_a(~64'd0, m, sh, md, (~64'd0) / 64'd7, "R7 cfg d=7");
    put_a(64'd3, 64'd4, 0, 2'd3, 64'd3, "R7 cfg shift0");
    put_a(64'd3, 64'd4, 0, 2'd2, 64'd0, "R7 cfg compare");

    for (int i = 0; i < 20000; i++) begin
      case ($urandom % 4)
        0: d = 64'(2 + ($urandom % 999));
        1: d = 64'd1 << ($urandom % 64);
        2: d = {1'b1, 31'($urandom), 32'($urandom)};
        default: d = {$urandom, $urandom};
      endcase
      if (d == 64'd0) d = 64'd3;
      make_cfg(64, d, m, sh, md);
      if (md == 2'd3) m = {$urandom, $urandom};
      case ($urandom % 4)
        0: n = ~64'd0;
        1: n = d - 64'd1;
        2: n = d * 64'($urandom % 1000);
        default: n = {$urandom, $urandom};
      endcase
      put_a(n, m, sh, md, n / d, mode_tag(md));
      if (($urandom % 8) == 0) idle_a();
    end
    idle_a();
  endtask

  task automatic run_b();
    logic [63:0] m;
    int sh;
    logic [1:0] md;
    logic [15:0] d;
    // R10 / R4: exhaustive for divisor 7 at N = 16
    make_cfg(16, 64'd7, m, sh, md);
    for (int n = 0; n < 65536; n++) begin
      put_b(16'(n), m[15:0], sh, md, 16'(n) / 16'd7, "R10 exhaustive d=7");
    end
    idle_b();
    for (int i = 0; i < 4000; i++) begin
      d = 16'($urandom);
      if (d == 16'd0) d = 16'd9;
      make_cfg(16, 64'(d), m, sh, md);
      begin
        logic [15:0] n;
        n = (($urandom % 3) == 0) ? 16'hFFFF : 16'($urandom);
        put_b(n, m[15:0], sh, md, n / d, mode_tag(md));
      end
      if (($urandom % 8) == 0) idle_b();
    end
    idle_b();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset valid (64)", 64'(a_ov), 64'd0);
    check("R1 reset quotient (64)", a_q, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 first cycle valid (64)", 64'(a_ov), 64'd0);
    check("R1 first cycle quotient (64)", a_q, 64'd0);
    check("R1 first cycle valid (16)", 64'(b_ov), 64'd0);
    check("R1 first cycle quotient (16)", 64'(b_q), 64'd0);
    mon_on = 1'b1;
    fork
      run_a();
      run_b();
    join
    repeat (6) @(posedge clk);
    #1;
    check("R2 all results returned (64)", 64'(qa.size()), 64'd0);
    check("R2 all results returned (16)", 64'(qb.size()), 64'd0);
    summary();
    $finish;
  end

endmodule